// File: doc/BRIEF.md
# Scatter-Gather DMA Chunk Walker

This is a single-channel DMA engine. It executes a chain of transfer chunks whose descriptors sit in a small on-chip table. Software fills table entries through a write port. Each entry holds:
- a source address and a destination address
- a separate hold-or-advance choice for each side
- a beat width code and a burst length
- a byte count
- an optional request-line pacing flag
- the index of the following entry

A start pulse names the head entry. The engine then runs the chain in link order and moves one beat per cycle through a word-wide read port and write port. Each beat copies the read data straight to the write side.

Before the first beat, the engine walks the chain once to add up its byte counts. It then reports the bytes still to move, and it lowers that figure only when a burst finishes. In ring mode a link of zero sends the engine back to the head entry and the remaining-bytes figure restarts at the ring total. Pause stalls the engine between beats. Abort drops it back to idle.

Top module: `sg_dma_walker`

## Requirements
- R1: After reset the engine is idle: busy, done, err, rd_en and wr_en are low and residue is zero.
- R2: After a start pulse the engine executes the chunks in link order from the head entry. A link index of zero ends the chain. After the final beat of the chain, done is high for exactly one cycle, busy falls, and no further beat is issued.
- R3: The width code sets the beat size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. A chunk takes count/size beats. On an advancing side the address steps by the beat size after each beat, starting at the descriptor address. On a held side the address stays at the descriptor address. wr_data equals rd_data and wr_size carries the width code.
- R4: A chunk with width code 3, a zero byte count, or a count that is not a multiple of its beat size raises err. The engine then stops with busy low, issues no beat from that chunk onward, and does not raise done. Beats of earlier chunks still complete. Abort or a new start clears err.
- R5: The burst field b gives bursts of b+1 beats, counted from the first beat of each chunk. burst_last is high on every (b+1)-th beat of a chunk and on the chunk's final beat.
- R6: A chunk with its pacing flag set issues a beat only in cycles where dreq is high.
- R7: Residue equals the sum of the byte counts of the chain at the first beat. After each beat that has burst_last, residue falls by the bytes of that burst from the next cycle on. It reads zero when done is asserted.
- R8: In ring mode a zero link returns to the head entry instead of finishing. done is never asserted, and residue restarts at the ring total at the first beat of every lap.
- R9: While pause is high no beat is issued. Once pause falls, the transfer continues at the next address with no beat lost or repeated.
- R10: While abort is high no beat is issued. From the following cycle busy is low, and done is not asserted for the aborted chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one descriptor entry |
| cfg_idx | input | IW | Entry index to write |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_len | input | LW | Chunk byte count |
| cfg_next | input | IW | Following entry index, zero ends the chain |
| cfg_src_inc | input | 1 | Source address advances when high |
| cfg_dst_inc | input | 1 | Destination address advances when high |
| cfg_width | input | 2 | Beat width code |
| cfg_burst | input | BW | Beats per burst minus one |
| cfg_paced | input | 1 | Chunk waits on dreq |
| start | input | 1 | Begin the chain at start_idx |
| start_idx | input | IW | Head entry |
| cyclic | input | 1 | Ring mode, captured at start |
| pause | input | 1 | Hold between beats |
| abort | input | 1 | Return to idle |
| dreq | input | 1 | Peripheral request line |
| rd_en | output | 1 | Read beat |
| rd_addr | output | AW | Read address |
| rd_data | input | 32 | Read data, same cycle |
| wr_en | output | 1 | Write beat |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Write data |
| wr_size | output | 2 | Width code of the beat |
| burst_last | output | 1 | Final beat of a burst |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle end-of-chain pulse |
| err | output | 1 | Halted on a malformed chunk |
| residue | output | LW+IW | Bytes still to move |

## Verification
The assertions assume three things about the inputs. Descriptor entries are not rewritten while a chain that uses them is running. dreq and pause are steady within a cycle. rd_data is returned in the same cycle as rd_en. The bench meets these by doing all its table writes while the engine is idle, by driving every input one time unit after the rising edge, and by returning rd_data as a combinational function of rd_addr. The sweep covers every legal width code, the burst lengths from one to four beats and several beat counts. A reference model in the bench predicts the address, burst flag and residue of every beat.

// File: rtl/sg_dma_walker.sv
module sg_dma_walker #(
  parameter int AW    = 16,
  parameter int LW    = 12,
  parameter int BW    = 3,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int RW   = LW + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [LW-1:0] cfg_len,
  input  logic [IW-1:0] cfg_next,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic [1:0]    cfg_width,
  input  logic [BW-1:0] cfg_burst,
  input  logic          cfg_paced,
  input  logic          start,
  input  logic [IW-1:0] start_idx,
  input  logic          cyclic,
  input  logic          pause,
  input  logic          abort,
  input  logic          dreq,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic [1:0]    wr_size,
  output logic          burst_last,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [RW-1:0] residue
);
  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_LOAD, S_XFER, S_ERR} st_t;

  logic [AW-1:0] m_src [DEPTH];
  logic [AW-1:0] m_dst [DEPTH];
  logic [LW-1:0] m_len [DEPTH];
  logic [IW-1:0] m_nxt [DEPTH];
  logic [1:0]    m_w   [DEPTH];
  logic [BW-1:0] m_b   [DEPTH];
  logic          m_si  [DEPTH];
  logic          m_di  [DEPTH];
  logic          m_pc  [DEPTH];

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      m_src[cfg_idx] <= cfg_src;
      m_dst[cfg_idx] <= cfg_dst;
      m_len[cfg_idx] <= cfg_len;
      m_nxt[cfg_idx] <= cfg_next;
      m_w[cfg_idx]   <= cfg_width;
      m_b[cfg_idx]   <= cfg_burst;
      m_si[cfg_idx]  <= cfg_src_inc;
      m_di[cfg_idx]  <= cfg_dst_inc;
      m_pc[cfg_idx]  <= cfg_paced;
    end
  end

  st_t           st;
  logic [IW-1:0] ptr, head, nxt, scnt;
  logic          ring, si, di, pc;
  logic [AW-1:0] sa, da;
  logic [LW-1:0] left, bacc;
  logic [BW-1:0] bcnt, bsz;
  logic [1:0]    wc;
  logic [RW-1:0] sum, total;

  logic [LW-1:0] wb;
  logic [RW-1:0] sum_n;
  logic          beat, chunk_end, bad;

  assign wb        = (wc == 2'd2) ? LW'(4) : (wc == 2'd1) ? LW'(2) : LW'(1);
  assign beat      = (st == S_XFER) && !pause && !abort && (!pc || dreq);
  assign chunk_end = beat && (left == wb);
  assign burst_last = beat && ((bcnt == bsz) || (left == wb));
  assign sum_n     = sum + RW'(m_len[ptr]);
  assign bad       = (m_w[ptr] == 2'd3) || (m_len[ptr] == '0) ||
                     ((m_w[ptr] == 2'd1) && m_len[ptr][0]) ||
                     ((m_w[ptr] == 2'd2) && (m_len[ptr][1:0] != 2'b00));

  assign rd_en   = beat;
  assign wr_en   = beat;
  assign rd_addr = sa;
  assign wr_addr = da;
  assign wr_data = rd_data;
  assign wr_size = wc;
  assign busy    = (st == S_SCAN) || (st == S_LOAD) || (st == S_XFER);
  assign err     = (st == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; head <= '0; nxt <= '0; scnt <= '0;
      ring <= 1'b0; si <= 1'b0; di <= 1'b0; pc <= 1'b0;
      sa <= '0; da <= '0; left <= '0; bacc <= '0; bcnt <= '0; bsz <= '0;
      wc <= '0; sum <= '0; total <= '0; residue <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) st <= S_IDLE;
      else case (st)
        S_IDLE, S_ERR: if (start) begin
          st <= S_SCAN; ptr <= start_idx; head <= start_idx; ring <= cyclic;
          sum <= '0; scnt <= '0; residue <= '0;
        end
        S_SCAN: begin
          if (m_nxt[ptr] == '0 || scnt == IW'(DEPTH - 1)) begin
            total <= sum_n; residue <= sum_n; ptr <= head; st <= S_LOAD;
          end else begin
            sum <= sum_n; ptr <= m_nxt[ptr]; scnt <= scnt + 1'b1;
          end
        end
        S_LOAD: begin
          sa <= m_src[ptr]; da <= m_dst[ptr]; left <= m_len[ptr];
          nxt <= m_nxt[ptr]; wc <= m_w[ptr]; bsz <= m_b[ptr];
          si <= m_si[ptr]; di <= m_di[ptr]; pc <= m_pc[ptr];
          bcnt <= '0; bacc <= '0;
          st <= bad ? S_ERR : S_XFER;
        end
        S_XFER: if (beat) begin
          if (si) sa <= sa + AW'(wb);
          if (di) da <= da + AW'(wb);
          left <= left - wb;
          if (burst_last) begin
            bcnt <= '0; bacc <= '0;
            residue <= residue - RW'(bacc) - RW'(wb);
          end else begin
            bcnt <= bcnt + 1'b1; bacc <= bacc + wb;
          end
          if (chunk_end) begin
            if (nxt != '0) begin
              ptr <= nxt; st <= S_LOAD;
            end else if (ring) begin
              ptr <= head; residue <= total; st <= S_LOAD;
            end else begin
              st <= S_IDLE; done <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_paced_dreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pc) |-> dreq);
  p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> !wr_en && !rd_en);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_residue_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && $past(st) == S_XFER) |-> residue <= $past(residue));
  p_held_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !si && st == S_XFER && $past(st) == S_XFER && $past(rd_en))
      |-> rd_addr == $past(rd_addr));
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !done);
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done && !wr_en);
endmodule

// File: tb/test_sg_dma_walker.sv
module test_sg_dma_walker;
  localparam int AW = 16, LW = 12, BW = 3, DEPTH = 8, IW = 3, RW = LW + IW;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_src_inc = 0, cfg_dst_inc = 0, cfg_paced = 0;
  logic [IW-1:0] cfg_idx = 0, cfg_next = 0, start_idx = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [LW-1:0] cfg_len = 0;
  logic [1:0] cfg_width = 0;
  logic [BW-1:0] cfg_burst = 0;
  logic start = 0, cyclic = 0, pause = 0, abort = 0, dreq;
  logic rd_en, wr_en, burst_last, busy, done, err;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic [1:0] wr_size;
  logic [RW-1:0] residue;

  always #5 clk = ~clk;

  sg_dma_walker #(.AW(AW), .LW(LW), .BW(BW), .DEPTH(DEPTH)) i_sg_dma_walker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len), .cfg_next(cfg_next),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .cfg_width(cfg_width),
    .cfg_burst(cfg_burst), .cfg_paced(cfg_paced), .start(start),
    .start_idx(start_idx), .cyclic(cyclic), .pause(pause), .abort(abort),
    .dreq(dreq), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size),
    .burst_last(burst_last), .busy(busy), .done(done), .err(err),
    .residue(residue));

  assign rd_data = {16'hC3A5, rd_addr};

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int cyc = 0;
  bit paced_mode = 0;
  initial forever begin @(posedge clk); #1; cyc++; end
  assign dreq = paced_mode && (cyc % 3 != 0);

  int b_src[DEPTH], b_dst[DEPTH], b_len[DEPTH], b_nxt[DEPTH], b_w[DEPTH], b_b[DEPTH];
  bit b_si[DEPTH], b_di[DEPTH], b_pc[DEPTH];

  int e_rd[1024], e_wr[1024], e_sz[1024], e_bl[1024], e_rs[1024];
  int nexp = 0, mi = 0, done_seen = 0;
  bit allow_extra = 0;

  task automatic wdesc(input int i, input int s, input int d, input int len, input int nx,
                       input bit si, input bit di, input int w, input int b, input bit pc);
    b_src[i] = s; b_dst[i] = d; b_len[i] = len; b_nxt[i] = nx;
    b_si[i] = si; b_di[i] = di; b_w[i] = w; b_b[i] = b; b_pc[i] = pc;
    @(posedge clk); #1;
    cfg_we = 1; cfg_idx = IW'(i); cfg_src = AW'(s); cfg_dst = AW'(d); cfg_len = LW'(len);
    cfg_next = IW'(nx); cfg_src_inc = si; cfg_dst_inc = di; cfg_width = 2'(w);
    cfg_burst = BW'(b); cfg_paced = pc;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic build(input int hd, input int laps);
    int total = 0, p = hd, n = 0, res;
    do begin total += b_len[p]; p = b_nxt[p]; n++; end while (p != 0 && n < DEPTH);
    nexp = 0;
    for (int l = 0; l < laps; l++) begin
      res = total; p = hd; n = 0;
      do begin
        int w = 1 << b_w[p];
        int acc = 0;
        if (b_w[p] == 3 || b_len[p] == 0 || (b_len[p] % w) != 0) return;
        for (int k = 0; k < b_len[p] / w; k++) begin
          e_rd[nexp] = (b_src[p] + (b_si[p] ? k * w : 0)) & 16'hFFFF;
          e_wr[nexp] = (b_dst[p] + (b_di[p] ? k * w : 0)) & 16'hFFFF;
          e_sz[nexp] = b_w[p];
          e_bl[nexp] = (((k + 1) % (b_b[p] + 1)) == 0 || k == b_len[p] / w - 1) ? 1 : 0;
          e_rs[nexp] = res;
          acc += w;
          if (e_bl[nexp] == 1) begin res -= acc; acc = 0; end
          nexp++;
        end
        p = b_nxt[p]; n++;
      end while (p != 0 && n < DEPTH);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (mi < nexp) begin
        chk(rd_addr == AW'(e_rd[mi]), "R3 rd_addr", rd_addr, e_rd[mi]);
        chk(wr_addr == AW'(e_wr[mi]), "R3 wr_addr", wr_addr, e_wr[mi]);
        chk(wr_size == 2'(e_sz[mi]) && wr_data == rd_data, "R3 size/data", wr_size, e_sz[mi]);
        chk(burst_last == e_bl[mi][0], "R5 burst_last", burst_last, e_bl[mi]);
        chk(residue == RW'(e_rs[mi]), "R7 residue", residue, e_rs[mi]);
      end else if (!allow_extra) chk(0, "R2 unexpected beat", mi, nexp);
      if (paced_mode) chk(dreq, "R6 beat without dreq", 0, 1);
      if (pause) chk(0, "R9 beat while paused", 1, 0);
      mi++;
    end
    if (done) done_seen++;
  end

  task automatic kick(input int hd, input bit cy);
    mi = 0; done_seen = 0;
    @(posedge clk); #1; start = 1; start_idx = IW'(hd); cyclic = cy;
    @(posedge clk); #1; start = 0;
  endtask

  task automatic wait_end;
    for (int t = 0; t < 3000 && !done && !err; t++) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  task automatic run_ok(input int hd, input string tag);
    build(hd, 1); allow_extra = 0;
    kick(hd, 0); wait_end();
    chk(mi == nexp, {tag, " R2 beat count"}, mi, nexp);
    chk(done_seen == 1, {tag, " R2 done once"}, done_seen, 1);
    chk(!busy && residue == 0, {tag, " R7 residue zero at end"}, residue, 0);
  endtask

  initial begin
    int cnt = 0;
    forever begin @(posedge clk); cnt++;
      if (cnt > 150000) begin
        chk(0, "watchdog", cnt, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !err && !wr_en && !rd_en && residue == 0, "R1 reset state", residue, 0);

    // R2/R3/R5: three chunks in scrambled link order
    wdesc(5, 16'h1000, 16'h4000, 8, 2, 1, 1, 2, 1, 0);
    wdesc(2, 16'h2001, 16'h0F00, 6, 7, 1, 0, 0, 3, 0);
    wdesc(7, 16'h3000, 16'h5002, 10, 0, 0, 1, 1, 2, 0);
    run_ok(5, "chain");

    // R3/R5/R7 sweep: every width, burst 1..4 beats, several beat counts
    for (int w = 0; w < 3; w++)
      for (int b = 0; b < 4; b++)
        for (int n = 1; n <= 7; n += 3) begin
          wdesc(1, 16'h0100 + w, 16'h0800, n << w, 0, (b & 1) == 0, n != 4, w, b, 0);
          run_ok(1, "sweep");
        end

    // R6 pacing
    wdesc(3, 16'h6000, 16'h7000, 12, 4, 1, 0, 1, 1, 1);
    wdesc(4, 16'h6100, 16'h7100, 8, 0, 0, 1, 2, 0, 1);
    paced_mode = 1; run_ok(3, "R6 paced"); paced_mode = 0;

    // R9 pause mid-chunk
    wdesc(1, 16'h0200, 16'h0A00, 40, 0, 1, 1, 0, 2, 0);
    build(1, 1); allow_extra = 0; kick(1, 0);
    for (int t = 0; t < 50 && mi < 6; t++) begin @(posedge clk); #1; end
    pause = 1;
    repeat (6) begin @(negedge clk); chk(!wr_en && busy, "R9 stalled while paused", wr_en, 0); end
    @(posedge clk); #1; pause = 0;
    wait_end();
    chk(mi == nexp && done_seen == 1, "R9 resume completes", mi, nexp);

    // R4 illegal width code
    wdesc(6, 16'h0, 16'h0, 8, 0, 1, 1, 3, 0, 0);
    build(6, 1); allow_extra = 0; kick(6, 0); wait_end();
    chk(err && !busy, "R4 err on width code 3", err, 1);
    chk(mi == 0 && done_seen == 0, "R4 no beats no done", mi, 0);
    @(posedge clk); #1; abort = 1; @(posedge clk); #1; abort = 0;
    chk(!err && !busy, "R4 abort clears err", err, 0);

    // R4 bad count in second chunk, first chunk completes
    wdesc(2, 16'h0300, 16'h0B00, 4, 3, 1, 1, 0, 0, 0);
    wdesc(3, 16'h0400, 16'h0C00, 6, 0, 1, 1, 2, 0, 0);
    build(2, 1); allow_extra = 0; kick(2, 0); wait_end();
    repeat (5) @(posedge clk); #1;
    chk(err && mi == 4 && nexp == 4, "R4 halt after good chunk", mi, 4);
    chk(done_seen == 0, "R4 no done", done_seen, 0);
    wdesc(3, 16'h0400, 16'h0C00, 0, 0, 1, 1, 0, 0, 0);
    build(3, 1); kick(3, 0); wait_end();
    chk(err && mi == 0, "R4 zero count", mi, 0);
    @(posedge clk); #1; abort = 1; @(posedge clk); #1; abort = 0;

    // R10 abort mid-chunk
    begin
      int m0;
      wdesc(1, 16'h0500, 16'h0D00, 32, 0, 1, 1, 0, 1, 0);
      build(1, 1); allow_extra = 1; kick(1, 0);
      for (int t = 0; t < 50 && mi < 5; t++) begin @(posedge clk); #1; end
      abort = 1; m0 = mi;
      @(negedge clk); chk(!wr_en, "R10 no beat during abort", wr_en, 0);
      @(posedge clk); #1; abort = 0;
      chk(!busy, "R10 busy low after abort", busy, 0);
      repeat (20) @(posedge clk); #1;
      chk(mi == m0 && done_seen == 0, "R10 stopped, no done", mi, m0);
    end

    // R8 ring: three laps over two chunks
    wdesc(4, 16'h0600, 16'h0E00, 6, 6, 1, 1, 1, 1, 0);
    wdesc(6, 16'h0700, 16'h0F00, 4, 0, 1, 0, 0, 2, 0);
    build(4, 3); allow_extra = 1; kick(4, 1);
    for (int t = 0; t < 200 && mi < nexp; t++) begin @(posedge clk); #1; end
    chk(mi >= nexp && busy, "R8 ring still running", mi, nexp);
    chk(done_seen == 0, "R8 no done in ring", done_seen, 0);
    abort = 1; @(posedge clk); #1; abort = 0;
    chk(!busy, "R8 abort stops ring", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule